// File: doc/BRIEF.md
# Fuse-Link PROM Single-Bit Burn Sequencer

This block steers the burning of one bit in a bipolar fuse-link PROM. A host gives it a word address, a bit index and a start strobe. The block then runs a fixed envelope of supply and select timing. It presents the address, lifts the select line, and asks an external switch to raise the device supply to the elevated programming level. It then connects only the chosen output to the programming voltage and drops select low for a timed programming pulse. After that it brings the supply back down and samples a verify line that reports whether the chosen output now reads high.

If the fuse is still intact, the block waits out a cool-off period and repeats the pulse with a longer width. There are three widths in all: initial, typical and maximum. The cool-off after each pulse is a fixed multiple of the width just applied. When the maximum-width attempt also fails, a sticky fail flag is raised. The block only generates enables and timing. All durations are parameters counted in clock cycles, and each window runs at its lower bound.

Top module: `fuse_burn_seq`

## Requirements
- R1: On a start strobe taken while idle, `addr_i` and `bit_i` are captured. `addr_o` shows the captured address and stays constant for the whole busy period. A start strobe while busy is ignored, including any change of `addr_i` at that moment.
- R2: `prog_en_o` is either all zero or has exactly bit `bit_i` set, using the captured index with bit 0 as the LSB. It is nonzero for exactly T_ARM + width + T_RELEASE cycles per attempt, and only while `vpp_hi_o` is high.
- R3: The sequence starts with T_ADDR_SETUP cycles in which the address is presented while select, the supply raise and all programming enables are low.
- R4: Select is high for T_SEL_LEAD cycles before `vpp_hi_o` rises, on every attempt.
- R5: `vpp_hi_o` and select are both high for T_RAMP_UP + T_ARM cycles before the programming pulse starts.
- R6: The programming pulse (select low while `vpp_hi_o` is high) lasts W_INIT cycles on the first attempt, W_TYP on the second and W_MAX on the third.
- R7: After the pulse, `vpp_hi_o` stays high for T_RELEASE cycles with select high. Select then stays high, with `vpp_hi_o` low, for T_RAMP_DN + T_SEL_TRAIL + 1 cycles.
- R8: `verify_i` is sampled in the last select-high cycle of each attempt. If it is high, no further pulse follows, so the number of attempts is the first one whose verify reads high, capped at three.
- R9: After each attempt, select and `vpp_hi_o` stay low for COOL_MULT times the width just used, before either the next attempt or the end.
- R10: If verify is still low after the third attempt, `fail_o` rises with the end of the sequence. It stays high until the next accepted start, which clears it.
- R11: `supply_on_o` equals `busy_o`. `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| addr_i | input | ADDR_W | Word address to burn |
| bit_i | input | BIT_W | Index of the output bit to burn |
| verify_i | input | 1 | High when the selected output reads high (fuse open) |
| addr_o | output | ADDR_W | Address presented to the PROM |
| supply_on_o | output | 1 | Enable for the normal device supply |
| vpp_hi_o | output | 1 | Request for the elevated programming supply |
| sel_o | output | 1 | Select line; a low pulse while elevated is the burn pulse |
| prog_en_o | output | DATA_W | Per-output programming-voltage switch enables |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| fail_o | output | 1 | Sticky: all three attempts failed to verify |

## Verification
The bench sweeps every bit index. For each one it uses a fuse model that opens after one, two or three pulses, or never. The one-pulse case isolates the basic envelope and the first width. The two- and three-pulse cases show that the width ladder steps in order and that the cool-off follows the width just used. The never-opening case is the only one that may raise the fail flag. Some runs also pulse a start with a different address in the middle of a sequence, to show that the captured address and the attempt count do not move.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SEL_UP,
      ST_RAMP_UP,
      ST_ARM,
      ST_PULSE,
      ST_RELEASE,
      ST_RAMP_DN,
      ST_TRAIL,
      ST_CHECK,
      ST_COOL
   } fbs_state_e;

   function automatic int fbs_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/fbs_timer.sv
module fbs_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/fbs_bit_decode.sv
module fbs_bit_decode #(
   parameter int DATA_W = 8,
   parameter int BIT_W  = 3
) (
   input  logic [BIT_W-1:0]  bit_i,
   input  logic              en_i,
   output logic [DATA_W-1:0] onehot_o
);
   for (genvar g = 0; g < DATA_W; g++) begin : g_lane
      assign onehot_o[g] = en_i && (bit_i == BIT_W'(g));
   end
endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
   import fbs_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 4,
   parameter int T_ADDR_SETUP = 16,
   parameter int T_SEL_LEAD   = 100,
   parameter int T_RAMP_UP    = 1000,
   parameter int T_ARM        = 100,
   parameter int W_INIT       = 10000,
   parameter int W_TYP        = 50000,
   parameter int W_MAX        = 200000,
   parameter int T_RELEASE    = 100,
   parameter int T_RAMP_DN    = 1000,
   parameter int T_SEL_TRAIL  = 100,
   parameter int COOL_MULT    = 3,
   localparam int BIT_W       = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BIT_W-1:0]  bit_i,
   input  logic              verify_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              supply_on_o,
   output logic              vpp_hi_o,
   output logic              sel_o,
   output logic [DATA_W-1:0] prog_en_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o
);
   localparam int MAX_A   = fbs_max(fbs_max(T_ADDR_SETUP, T_SEL_LEAD), fbs_max(T_RAMP_UP, T_ARM));
   localparam int MAX_B   = fbs_max(fbs_max(T_RELEASE, T_RAMP_DN), fbs_max(T_SEL_TRAIL, W_MAX));
   localparam int MAX_DUR = fbs_max(fbs_max(MAX_A, MAX_B), COOL_MULT * W_MAX);
   localparam int CNT_W   = $clog2(MAX_DUR + 1);
   localparam logic [1:0] LAST_TRY = 2'd2;

   if (DATA_W < 2 || ADDR_W < 1) begin : g_bad_width
      $error("fuse_burn_seq: DATA_W must be >= 2 and ADDR_W >= 1");
   end
   if (W_INIT < 1 || W_INIT > W_TYP || W_TYP > W_MAX) begin : g_bad_ladder
      $error("fuse_burn_seq: widths must satisfy 1 <= W_INIT <= W_TYP <= W_MAX");
   end
   if (COOL_MULT < 3 || COOL_MULT > 4) begin : g_bad_cool
      $error("fuse_burn_seq: COOL_MULT must be 3 or 4");
   end
   if (T_ADDR_SETUP < 1 || T_SEL_LEAD < 1 || T_RAMP_UP < 1 || T_ARM < 1 ||
       T_RELEASE < 1 || T_RAMP_DN < 1 || T_SEL_TRAIL < 1) begin : g_bad_dur
      $error("fuse_burn_seq: every phase duration must be at least one cycle");
   end

   fbs_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [BIT_W-1:0]  bit_q;
   logic [1:0]        try_q;
   logic              blown_q, done_q, fail_q;
   logic              load, expire, prog_on;
   logic [CNT_W-1:0]  load_val;
   int                nxt_dur, cur_width;

   always_comb begin
      case (try_q)
         2'd0:    cur_width = W_INIT;
         2'd1:    cur_width = W_TYP;
         default: cur_width = W_MAX;
      endcase
   end

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      nxt_dur = 1;
      case (state_q)
         ST_IDLE:    if (start_i) begin state_d = ST_ADDR;    load = 1'b1; nxt_dur = T_ADDR_SETUP; end
         ST_ADDR:    if (expire)  begin state_d = ST_SEL_UP;  load = 1'b1; nxt_dur = T_SEL_LEAD;   end
         ST_SEL_UP:  if (expire)  begin state_d = ST_RAMP_UP; load = 1'b1; nxt_dur = T_RAMP_UP;    end
         ST_RAMP_UP: if (expire)  begin state_d = ST_ARM;     load = 1'b1; nxt_dur = T_ARM;        end
         ST_ARM:     if (expire)  begin state_d = ST_PULSE;   load = 1'b1; nxt_dur = cur_width;    end
         ST_PULSE:   if (expire)  begin state_d = ST_RELEASE; load = 1'b1; nxt_dur = T_RELEASE;    end
         ST_RELEASE: if (expire)  begin state_d = ST_RAMP_DN; load = 1'b1; nxt_dur = T_RAMP_DN;    end
         ST_RAMP_DN: if (expire)  begin state_d = ST_TRAIL;   load = 1'b1; nxt_dur = T_SEL_TRAIL;  end
         ST_TRAIL:   if (expire)  begin state_d = ST_CHECK;   load = 1'b1; nxt_dur = 1;            end
         ST_CHECK:   if (expire)  begin state_d = ST_COOL;    load = 1'b1; nxt_dur = COOL_MULT * cur_width; end
         ST_COOL: if (expire) begin
            if (blown_q || try_q == LAST_TRY) state_d = ST_IDLE;
            else begin state_d = ST_SEL_UP; load = 1'b1; nxt_dur = T_SEL_LEAD; end
         end
         default: state_d = ST_IDLE;
      endcase
      load_val = CNT_W'(nxt_dur - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         bit_q   <= '0;
         try_q   <= '0;
         blown_q <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= 1'b0;
         if (state_q == ST_IDLE && start_i) begin
            addr_q  <= addr_i;
            bit_q   <= bit_i;
            try_q   <= '0;
            blown_q <= 1'b0;
            fail_q  <= 1'b0;
         end
         if (state_q == ST_CHECK) blown_q <= verify_i;
         if (state_q == ST_COOL && expire) begin
            if (blown_q || try_q == LAST_TRY) begin
               done_q <= 1'b1;
               fail_q <= !blown_q;
            end else begin
               try_q <= try_q + 2'd1;
            end
         end
      end
   end

   fbs_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .expire_o   (expire)
   );

   assign prog_on = (state_q == ST_ARM) || (state_q == ST_PULSE) || (state_q == ST_RELEASE);

   fbs_bit_decode #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_decode (
      .bit_i    (bit_q),
      .en_i     (prog_on),
      .onehot_o (prog_en_o)
   );

   assign addr_o      = addr_q;
   assign busy_o      = (state_q != ST_IDLE);
   assign supply_on_o = busy_o;
   assign vpp_hi_o    = (state_q == ST_RAMP_UP) || prog_on;
   assign sel_o       = busy_o && (state_q != ST_ADDR) && (state_q != ST_PULSE) && (state_q != ST_COOL);
   assign done_o      = done_q;
   assign fail_o      = fail_q;

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(addr_o)); // R1
   AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(prog_en_o)); // R2
   AST_PROG_UNDER_VPP: assert property (@(posedge clk) disable iff (!rst_n)
      (|prog_en_o) |-> vpp_hi_o); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !sel_o && !vpp_hi_o && (prog_en_o == '0)); // R3
   AST_RAMP_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vpp_hi_o) |-> sel_o && $past(sel_o)); // R4
   AST_DROP_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vpp_hi_o) |-> sel_o); // R7
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o && !(start_i && !busy_o) |=> fail_o); // R10
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R11
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> !busy_o && $past(busy_o)); // R11
endmodule

// File: tb/fuse_burn_seq_bench.sv
module fuse_burn_seq_bench;
   localparam int AW = 4, DW = 8, BW = 3;
   localparam int TA = 3, TL = 4, TU = 5, TR = 2, W0 = 6, W1 = 9, W2 = 12;
   localparam int TP = 2, TD = 5, TT = 3, CM = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, verify_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [BW-1:0] bit_i = '0;
   logic [AW-1:0] addr_o;
   logic supply_on_o, vpp_hi_o, sel_o, busy_o, done_o, fail_o;
   logic [DW-1:0] prog_en_o;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   fuse_burn_seq #(
      .ADDR_W(AW), .DATA_W(DW), .T_ADDR_SETUP(TA), .T_SEL_LEAD(TL), .T_RAMP_UP(TU),
      .T_ARM(TR), .W_INIT(W0), .W_TYP(W1), .W_MAX(W2), .T_RELEASE(TP),
      .T_RAMP_DN(TD), .T_SEL_TRAIL(TT), .COOL_MULT(CM)
   ) u_fuse_burn_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .bit_i(bit_i),
      .verify_i(verify_i), .addr_o(addr_o), .supply_on_o(supply_on_o),
      .vpp_hi_o(vpp_hi_o), .sel_o(sel_o), .prog_en_o(prog_en_o), .busy_o(busy_o),
      .done_o(done_o), .fail_o(fail_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int width_of(input int k);
      return (k == 0) ? W0 : (k == 1) ? W1 : W2;
   endfunction

   task automatic run(input int bx, input int nopen, input int ad, input bit poke);
      int ssu[3], ramp[3], pw[3], post[3], tail[3], cool[3], pen[3];
      int pre_lo = 0, a = 0, ph = 0, cyc = 0, addr_bad = 0, pen_bad = 0, sup_bad = 0;
      int att;
      bit seen_done = 1'b0, fail_seen = 1'b0;
      logic [DW-1:0] mask;
      mask = DW'(1) << bx;
      for (int k = 0; k < 3; k++) begin
         ssu[k] = 0; ramp[k] = 0; pw[k] = 0; post[k] = 0; tail[k] = 0; cool[k] = 0; pen[k] = 0;
      end
      att = (nopen > 3) ? 3 : nopen;
      @(negedge clk);
      addr_i = AW'(ad); bit_i = BW'(bx); verify_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(fail_o == 1'b0, "R10 fail cleared by start", int'(fail_o), 0);
      while (!seen_done && cyc < 3000) begin
         if (poke && cyc == 20) begin start_i = 1'b1; addr_i = ~AW'(ad); end
         else if (poke && cyc == 21) begin start_i = 1'b0; addr_i = AW'(ad); end
         if (done_o) begin
            seen_done = 1'b1;
            fail_seen = fail_o;
            chk(!busy_o, "R11 busy low with done", int'(busy_o), 0);
         end else begin
            if (supply_on_o !== busy_o) sup_bad++;
            if (busy_o) begin
               if (addr_o !== AW'(ad)) addr_bad++;
               if (ph == 1 && sel_o && a < 3 && cool[a] > 0) begin a++; ph = 0; end
               if (prog_en_o != '0) begin
                  if (a < 3) pen[a]++;
                  if (prog_en_o !== mask) pen_bad++;
               end
               if (a < 3) begin
                  if (!sel_o && !vpp_hi_o) begin
                     if (ph == 0) pre_lo++; else cool[a]++;
                  end else if (sel_o && !vpp_hi_o) begin
                     if (ph == 1) tail[a]++; else ssu[a]++;
                  end else if (sel_o && vpp_hi_o) begin
                     if (ph == 1) post[a]++; else ramp[a]++;
                  end else begin
                     ph = 1; pw[a]++;
                  end
               end
            end
            verify_i = (ph == 1) && (a + 1 >= nopen);
            cyc++;
            @(negedge clk);
         end
      end
      chk(seen_done, "R11 done pulse seen", int'(seen_done), 1);
      chk(fail_seen == (nopen > 3), "R10 fail flag at end", int'(fail_seen), int'(nopen > 3));
      chk(a + 1 == att, "R8 attempt count", a + 1, att);
      chk(pre_lo == TA, "R3 address setup cycles", pre_lo, TA);
      chk(addr_bad == 0, "R1 address held while busy", addr_bad, 0);
      chk(pen_bad == 0, "R2 enable lane", pen_bad, 0);
      chk(sup_bad == 0, "R11 supply follows busy", sup_bad, 0);
      for (int k = 0; k < 3; k++) begin
         if (k < att) begin
            chk(ssu[k] == TL, "R4 select lead", ssu[k], TL);
            chk(ramp[k] == TU + TR, "R5 raised before pulse", ramp[k], TU + TR);
            chk(pw[k] == width_of(k), "R6 pulse width", pw[k], width_of(k));
            chk(post[k] == TP, "R7 raised after pulse", post[k], TP);
            chk(tail[k] == TD + TT + 1, "R7 select trail", tail[k], TD + TT + 1);
            chk(cool[k] == CM * width_of(k), "R9 cool-off", cool[k], CM * width_of(k));
            chk(pen[k] == TR + width_of(k) + TP, "R2 enable window", pen[k], TR + width_of(k) + TP);
         end
      end
      @(negedge clk);
      chk(!done_o, "R11 done one cycle", int'(done_o), 0);
      chk(!busy_o && !sel_o && !vpp_hi_o, "R11 idle after end", int'(busy_o), 0);
      chk(fail_o == (nopen > 3), "R10 fail sticky", int'(fail_o), int'(nopen > 3));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !fail_o, "R11 reset flags", int'({busy_o, done_o, fail_o}), 0);
      chk(!sel_o && !vpp_hi_o && !supply_on_o, "R3 reset drive", int'({sel_o, vpp_hi_o, supply_on_o}), 0);
      chk(prog_en_o == '0, "R2 reset enables", int'(prog_en_o), 0);
      rst_n = 1'b1;
      for (int b = 0; b < DW; b++) begin
         for (int n = 1; n <= 4; n++) begin
            run(b, n, (b * 5 + n * 3) % 16, (b == 3) || (n == 4 && b == 6));
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule